// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel Register Block

This block is the register front end of one channel of a PCI IDE bus-master DMA engine. A host issues byte or dword I/O accesses at offsets 0 to 7 through a simple valid/ready port. Inside the block sit a command byte, a status byte whose bits follow different write rules, and a 32-bit descriptor-table base address. The command bits drive the data mover, which is not part of this block. The status byte collects completion events from that mover and interrupt events from the attached drive.

A static strap, `ext_type`, selects between two controller variants. In the basic variant, offsets 1 and 3 are unused. In the extended variant they pass through to configuration storage that is shared between channels and lives outside the block. Offset 1 carries a controller-wide mode byte, and only two of its bits can be changed from here. Offset 3 carries a timing byte that belongs to this channel, chosen by the `CHANNEL` parameter.

Accesses are sequenced by a two-state machine. In `ST_IDLE` the block raises `acc_ready`. An accepted access moves the machine to `ST_REPLY` (the IDLE_TO_REPLY transition), and the machine always returns to `ST_IDLE` on the next edge (the REPLY_TO_IDLE transition).

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, the command, status and address registers read as zero, `cmd_start`, `cmd_read` and `irq_pending` are 0, and `acc_ready` is 1.
- R2: An access is accepted on an edge where `acc_valid` and `acc_ready` are both 1. `acc_ready` is then 0 for exactly one cycle. For a read, `rd_valid` is 1 in that same cycle only. A byte read returns its byte in `rd_data[7:0]`, with `rd_data[31:8]` zero.
- R3: A byte at offset 0 is the command register and reads back what was written. `cmd_start` is command bit 0 and `cmd_read` is command bit 3. No other access changes them.
- R4: A byte write at offset 2 sets status bits 6 and 5 to the written values. It clears status bits 2 and 1 where the written bit is 1 and leaves them alone where it is 0. Status bits 7, 4 and 3 always read 0. Status bit 0 follows `eng_busy`, one cycle late, and ignores writes.
- R5: A one-cycle `eng_err` sets status bit 1. `drv_irq_evt` sets status bit 2 unless `drv_irq_dis` is 1 in the same cycle. When a set and a write-one-to-clear of the same bit fall in the same cycle, the set wins. `irq_pending` equals status bit 2.
- R6: A dword write at offset 4 loads the descriptor address. A dword read at offset 4 returns the whole address. Byte reads at offsets 4 to 7 return address bytes 0 to 3, least significant byte first. Byte writes at offsets 4 to 7 are ignored, as are dword writes at any other offset. A dword read at any other offset returns 0xFFFFFFFF.
- R7: With `ext_type` = 0, byte reads at offsets 1 and 3 return 0xFF. Writes at those offsets raise no configuration write enable.
- R8: With `ext_type` = 1, a byte read at offset 1 returns `mode_rd`. A byte write at offset 1 pulses `mode_we` for one cycle. During that pulse, `mode_wdata` carries bits 5 and 4 from the written byte and every other bit from `mode_rd` as it was in the accept cycle.
- R9: With `ext_type` = 1, a byte read at offset 3 returns this channel's timing byte: `tim0_rd` when `CHANNEL` is 0, `tim1_rd` when it is 1. A byte write at offset 3 pulses only that channel's enable (`tim0_we` or `tim1_we`) for one cycle, with the written byte on `tim_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_type | input | 1 | Controller variant strap: 0 basic, 1 extended |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 write, 0 read |
| acc_dword | input | 1 | 1 dword access, 0 byte access |
| acc_off | input | 3 | Register offset 0 to 7 |
| acc_wdata | input | 32 | Write data (a byte write uses bits 7:0) |
| acc_ready | output | 1 | Block can accept an access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| eng_busy | input | 1 | Data mover active, mirrored into status bit 0 |
| eng_err | input | 1 | Data mover error event |
| drv_irq_evt | input | 1 | Interrupt event from the drive channel |
| drv_irq_dis | input | 1 | Drive has its interrupt output disabled |
| cmd_start | output | 1 | Command start bit |
| cmd_read | output | 1 | Command direction bit |
| irq_pending | output | 1 | Status interrupt flag |
| mode_rd | input | 8 | Shared mode byte from configuration storage |
| mode_we | output | 1 | Mode byte write enable |
| mode_wdata | output | 8 | Merged mode byte to store |
| tim0_rd | input | 8 | Timing byte of channel 0 |
| tim1_rd | input | 8 | Timing byte of channel 1 |
| tim0_we | output | 1 | Channel 0 timing write enable |
| tim1_we | output | 1 | Channel 1 timing write enable |
| tim_wdata | output | 8 | Timing byte to store |

## Verification
A corrupted status bit shows up at `irq_pending` on the next edge, or in the first status read that follows. A register that holds a wrong value is not visible until the next read of its offset, so every write is followed, in directed or random order, by a read of the same or an aliased offset. A mis-decoded write enable reaches the external storage model at once. A later read of offset 1 or 3 then returns a value that differs from the model's.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int OFF_W = 3;
    localparam logic [OFF_W-1:0] OFF_CMD  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_MODE = 3'd1;
    localparam logic [OFF_W-1:0] OFF_STAT = 3'd2;
    localparam logic [OFF_W-1:0] OFF_TIM  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_ADDR = 3'd4;

    localparam logic [7:0] MODE_WR_MASK = 8'h30;
    localparam logic [7:0] STAT_RW_MASK = 8'h60;
    localparam logic [7:0] STAT_W1C_MASK = 8'h06;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } acc_state_e;

    typedef struct packed {
        logic             wr;
        logic             dword;
        logic [OFF_W-1:0] off;
        logic [31:0]      data;
    } acc_req_t;
endpackage

// File: rtl/bmdma_access_fsm.sv
module bmdma_access_fsm
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_wr,
    output logic ready,
    output logic accept,
    output logic rd_valid
);
    acc_state_e state_q, state_d;
    logic       was_read_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            was_read_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) was_read_q <= !req_wr;
        end
    end

    always_comb begin
        ready    = 1'b0;
        accept   = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready  = 1'b1;
                accept = req_valid;
            end
            ST_REPLY: rd_valid = was_read_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
    import bmdma_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         busy,
    input  logic         err_set,
    input  logic         irq_set,
    output logic [W-1:0] status
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt    = status & (STAT_RW_MASK | STAT_W1C_MASK);
        if (wr_en) begin
            nxt = (wdata & STAT_RW_MASK)
                | (status & STAT_W1C_MASK & ~wdata);
        end
        nxt[0] = busy;
        if (err_set) nxt[1] = 1'b1;
        if (irq_set) nxt[2] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= nxt;
    end
endmodule

// File: rtl/bmdma_cfg_port.sv
module bmdma_cfg_port
    import bmdma_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int NCHAN   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_type,
    input  logic             wr_mode,
    input  logic             wr_tim,
    input  logic [7:0]       wdata,
    input  logic [7:0]       mode_rd,
    input  logic [NCHAN-1:0][7:0] tim_rd,
    output logic [7:0]       mode_view,
    output logic [7:0]       tim_view,
    output logic             mode_we,
    output logic [7:0]       mode_wdata,
    output logic [NCHAN-1:0] tim_we,
    output logic [7:0]       tim_wdata
);
    logic tim_we_q;

    assign mode_view = ext_type ? mode_rd : 8'hFF;
    assign tim_view  = ext_type ? tim_rd[CHANNEL] : 8'hFF;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_we    <= 1'b0;
            mode_wdata <= '0;
            tim_we_q   <= 1'b0;
            tim_wdata  <= '0;
        end else begin
            mode_we  <= wr_mode && ext_type;
            tim_we_q <= wr_tim && ext_type;
            if (wr_mode && ext_type)
                mode_wdata <= (mode_rd & ~MODE_WR_MASK) | (wdata & MODE_WR_MASK);
            if (wr_tim && ext_type)
                tim_wdata <= wdata;
        end
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_tim_we
        if (c == CHANNEL) begin : g_own
            assign tim_we[c] = tim_we_q;
        end else begin : g_other
            assign tim_we[c] = 1'b0;
        end
    end
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int ADDR_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_type,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_dword,
    input  logic [2:0]  acc_off,
    input  logic [31:0] acc_wdata,
    output logic        acc_ready,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic        eng_busy,
    input  logic        eng_err,
    input  logic        drv_irq_evt,
    input  logic        drv_irq_dis,
    output logic        cmd_start,
    output logic        cmd_read,
    output logic        irq_pending,
    input  logic [7:0]  mode_rd,
    output logic        mode_we,
    output logic [7:0]  mode_wdata,
    input  logic [7:0]  tim0_rd,
    input  logic [7:0]  tim1_rd,
    output logic        tim0_we,
    output logic        tim1_we,
    output logic [7:0]  tim_wdata
);
    localparam int NBYTE = ADDR_W / 8;
    localparam int NCHAN = 2;

    acc_req_t   req;
    logic       accept;
    logic [7:0] cmd_q;
    logic [7:0] status;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0] mode_view, tim_view;
    logic [NCHAN-1:0][7:0] tim_rd_all;
    logic [NCHAN-1:0]      tim_we_all;
    logic       bw, bw_cmd, bw_stat, bw_mode, bw_tim, dw_addr;
    logic [7:0] byte_rd;
    logic [31:0] rd_nxt;
    logic [NBYTE-1:0][7:0] addr_bytes;

    assign req.wr    = acc_write;
    assign req.dword = acc_dword;
    assign req.off   = acc_off;
    assign req.data  = acc_wdata;

    bmdma_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(acc_valid),
        .req_wr   (acc_write),
        .ready    (acc_ready),
        .accept   (accept),
        .rd_valid (rd_valid)
    );

    assign bw      = accept && req.wr && !req.dword;
    assign bw_cmd  = bw && (req.off == OFF_CMD);
    assign bw_stat = bw && (req.off == OFF_STAT);
    assign bw_mode = bw && (req.off == OFF_MODE);
    assign bw_tim  = bw && (req.off == OFF_TIM);
    assign dw_addr = accept && req.wr && req.dword && (req.off == OFF_ADDR);

    bmdma_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bw_stat),
        .wdata  (req.data[7:0]),
        .busy   (eng_busy),
        .err_set(eng_err),
        .irq_set(drv_irq_evt && !drv_irq_dis),
        .status (status)
    );

    assign tim_rd_all[0] = tim0_rd;
    assign tim_rd_all[1] = tim1_rd;

    bmdma_cfg_port #(.CHANNEL(CHANNEL), .NCHAN(NCHAN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_type  (ext_type),
        .wr_mode   (bw_mode),
        .wr_tim    (bw_tim),
        .wdata     (req.data[7:0]),
        .mode_rd   (mode_rd),
        .tim_rd    (tim_rd_all),
        .mode_view (mode_view),
        .tim_view  (tim_view),
        .mode_we   (mode_we),
        .mode_wdata(mode_wdata),
        .tim_we    (tim_we_all),
        .tim_wdata (tim_wdata)
    );

    assign tim0_we = tim_we_all[0];
    assign tim1_we = tim_we_all[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            if (bw_cmd)  cmd_q  <= req.data[7:0];
            if (dw_addr) addr_q <= req.data[ADDR_W-1:0];
        end
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_abyte
        assign addr_bytes[b] = addr_q[8*b +: 8];
    end

    always_comb begin
        byte_rd = 8'hFF;
        unique case (req.off)
            3'd0: byte_rd = cmd_q;
            3'd1: byte_rd = mode_view;
            3'd2: byte_rd = status;
            3'd3: byte_rd = tim_view;
            3'd4: byte_rd = addr_bytes[0];
            3'd5: byte_rd = addr_bytes[1];
            3'd6: byte_rd = addr_bytes[2];
            3'd7: byte_rd = addr_bytes[3];
            default: byte_rd = 8'hFF;
        endcase
        if (req.dword)
            rd_nxt = (req.off == OFF_ADDR) ? addr_q : 32'hFFFF_FFFF;
        else
            rd_nxt = {24'h0, byte_rd};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data <= '0;
        else if (accept && !req.wr) rd_data <= rd_nxt;
    end

    assign cmd_start   = cmd_q[0];
    assign cmd_read    = cmd_q[3];
    assign irq_pending = status[2];
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_type,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_dword,
    input logic [2:0] acc_off,
    input logic       acc_ready,
    input logic       rd_valid,
    input logic       drv_irq_evt,
    input logic       drv_irq_dis,
    input logic       cmd_start,
    input logic       irq_pending,
    input logic [7:0] mode_rd,
    input logic       mode_we,
    input logic [7:0] mode_wdata,
    input logic       tim0_we,
    input logic       tim1_we
);
    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R2
    AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);  // R2
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_ready && acc_write && !acc_dword && acc_off == 3'd0)
        |=> $stable(cmd_start));  // R3
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_irq_evt && !drv_irq_dis) |=> irq_pending);  // R5
    AST_BASIC_NO_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_type && !$past(ext_type)) |-> !(mode_we || tim0_we || tim1_we));  // R7
    AST_MODE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |-> (((mode_wdata ^ $past(mode_rd)) & 8'hCF) == 8'h00));  // R8
    AST_CFG_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we || tim0_we || tim1_we) |=> !(mode_we || tim0_we || tim1_we));  // R9
endmodule

bind bmdma_regfile bmdma_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_type   (ext_type),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_dword  (acc_dword),
    .acc_off    (acc_off),
    .acc_ready  (acc_ready),
    .rd_valid   (rd_valid),
    .drv_irq_evt(drv_irq_evt),
    .drv_irq_dis(drv_irq_dis),
    .cmd_start  (cmd_start),
    .irq_pending(irq_pending),
    .mode_rd    (mode_rd),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .tim0_we    (tim0_we),
    .tim1_we    (tim1_we)
);

// File: tb/sim_bmdma_regfile.sv
`timescale 1ns/1ps
module sim_bmdma_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_type = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_dword = 1'b0;
    logic [2:0]  acc_off = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, rd_valid;
    logic [31:0] rd_data;
    logic        eng_busy = 1'b0, eng_err = 1'b0;
    logic        drv_irq_evt = 1'b0, drv_irq_dis = 1'b0;
    logic        cmd_start, cmd_read, irq_pending;
    logic [7:0]  mode_store, tim0_store, tim1_store;
    logic        mode_we, tim0_we, tim1_we;
    logic [7:0]  mode_wdata, tim_wdata;

    int checks = 0;
    int errors = 0;
    int stray  = 0;

    always #10 clk = ~clk;

    bmdma_regfile u0 (
        .clk(clk), .rst_n(rst_n), .ext_type(ext_type),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_dword(acc_dword),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_busy(eng_busy), .eng_err(eng_err),
        .drv_irq_evt(drv_irq_evt), .drv_irq_dis(drv_irq_dis),
        .cmd_start(cmd_start), .cmd_read(cmd_read), .irq_pending(irq_pending),
        .mode_rd(mode_store), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tim0_rd(tim0_store), .tim1_rd(tim1_store),
        .tim0_we(tim0_we), .tim1_we(tim1_we), .tim_wdata(tim_wdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mode_store <= 8'hC3; tim0_store <= 8'h5A; tim1_store <= 8'hA5;
        end else begin
            if (mode_we) mode_store <= mode_wdata;
            if (tim0_we) tim0_store <= tim_wdata;
            if (tim1_we) tim1_store <= tim_wdata;
            if (!ext_type && (mode_we || tim0_we || tim1_we)) stray++;
            if (tim1_we) stray++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_stat(input logic [7:0] s, input logic [7:0] w, input logic busy);
        logic [7:0] r;
        r = (w & 8'h60) | (s & 8'h06 & ~w);
        r[0] = busy;
        return r;
    endfunction

    function automatic logic [7:0] f_mode(input logic [7:0] m, input logic [7:0] w);
        return (m & 8'hCF) | (w & 8'h30);
    endfunction

    logic [31:0] rdv;

    task automatic access(input logic wr, input logic dw, input logic [2:0] off,
                          input logic [31:0] d, input logic evt, input string req);
        acc_valid = 1'b1; acc_write = wr; acc_dword = dw; acc_off = off; acc_wdata = d;
        drv_irq_evt = evt;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; drv_irq_evt = 1'b0;
        check({req, " ready low"}, {31'h0, acc_ready}, 32'h0);
        check({req, " rd_valid"}, {31'h0, rd_valid}, {31'h0, !wr});
        rdv = rd_data;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic ext);
        rst_n = 1'b0; ext_type = ext;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    logic [7:0]  m_cmd, m_stat, m_mode, m_tim;
    logic [31:0] m_addr;

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(1'b0);

        // R1 reset state
        check("R1 ready", {31'h0, acc_ready}, 32'h1);
        check("R1 start", {31'h0, cmd_start}, 32'h0);
        check("R1 irq", {31'h0, irq_pending}, 32'h0);
        access(0, 0, 3'd0, 0, 0, "R1"); check("R1 cmd", rdv, 32'h0);
        access(0, 0, 3'd2, 0, 0, "R1"); check("R1 status", rdv, 32'h0);
        access(0, 1, 3'd4, 0, 0, "R1"); check("R1 addr", rdv, 32'h0);

        // R3 command
        access(1, 0, 3'd0, 32'hFFFF_FF09, 0, "R3");
        check("R3 start", {31'h0, cmd_start}, 32'h1);
        check("R3 read", {31'h0, cmd_read}, 32'h1);
        access(0, 0, 3'd0, 0, 0, "R3"); check("R3 readback R2 upper", rdv, 32'h09);
        access(1, 0, 3'd0, 32'h08, 0, "R3");
        check("R3 start off", {31'h0, cmd_start}, 32'h0);

        // R4 status write rules
        eng_busy = 1'b1; @(negedge clk); @(negedge clk);
        access(1, 0, 3'd2, 32'hFF, 0, "R4");
        access(0, 0, 3'd2, 0, 0, "R4"); check("R4 write ff", rdv, 32'h61);
        access(1, 0, 3'd2, 32'h00, 0, "R4");
        access(0, 0, 3'd2, 0, 0, "R4"); check("R4 write 00", rdv, 32'h01);

        // R5 event sets
        eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
        drv_irq_dis = 1'b1; drv_irq_evt = 1'b1; @(negedge clk); drv_irq_evt = 1'b0; drv_irq_dis = 1'b0;
        check("R5 disabled irq", {31'h0, irq_pending}, 32'h0);
        drv_irq_evt = 1'b1; @(negedge clk); drv_irq_evt = 1'b0;
        check("R5 irq set", {31'h0, irq_pending}, 32'h1);
        access(0, 0, 3'd2, 0, 0, "R5"); check("R5 status", rdv, 32'h07);
        access(1, 0, 3'd2, 32'h02, 0, "R5");
        access(0, 0, 3'd2, 0, 0, "R5"); check("R5 clear err only", rdv, 32'h05);
        access(1, 0, 3'd2, 32'h04, 1, "R5");
        check("R5 set wins", {31'h0, irq_pending}, 32'h1);
        access(1, 0, 3'd2, 32'h04, 0, "R5");
        check("R5 cleared", {31'h0, irq_pending}, 32'h0);

        // R6 address
        access(1, 1, 3'd4, 32'hDEAD_BEEC, 0, "R6");
        access(0, 1, 3'd4, 0, 0, "R6"); check("R6 dword", rdv, 32'hDEAD_BEEC);
        access(0, 0, 3'd6, 0, 0, "R6"); check("R6 byte6", rdv, 32'hAD);
        access(0, 0, 3'd7, 0, 0, "R6"); check("R6 byte7", rdv, 32'hDE);
        access(1, 0, 3'd5, 32'h11, 0, "R6");
        access(0, 1, 3'd4, 0, 0, "R6"); check("R6 byte write ignored", rdv, 32'hDEAD_BEEC);
        access(1, 1, 3'd0, 32'h0000_0001, 0, "R6");
        check("R6 dword off0 ignored", {31'h0, cmd_start}, 32'h0);
        access(0, 1, 3'd0, 0, 0, "R6"); check("R6 dword elsewhere", rdv, 32'hFFFF_FFFF);

        // R7 basic variant
        access(0, 0, 3'd1, 0, 0, "R7"); check("R7 off1", rdv, 32'hFF);
        access(1, 0, 3'd1, 32'h30, 0, "R7");
        access(1, 0, 3'd3, 32'h12, 0, "R7");
        access(0, 0, 3'd3, 0, 0, "R7"); check("R7 off3", rdv, 32'hFF);
        check("R7 no cfg writes", stray, 0);

        // extended variant
        do_reset(1'b1);
        access(0, 0, 3'd1, 0, 0, "R8"); check("R8 read", rdv, 32'hC3);
        access(1, 0, 3'd1, 32'hFF, 0, "R8");
        access(0, 0, 3'd1, 0, 0, "R8"); check("R8 merge set", rdv, 32'hF3);
        access(1, 0, 3'd1, 32'h00, 0, "R8");
        access(0, 0, 3'd1, 0, 0, "R8"); check("R8 merge clr", rdv, 32'hC3);
        access(0, 0, 3'd3, 0, 0, "R9"); check("R9 read", rdv, 32'h5A);
        access(1, 0, 3'd3, 32'h77, 0, "R9");
        access(0, 0, 3'd3, 0, 0, "R9"); check("R9 readback", rdv, 32'h77);
        check("R9 other channel", {24'h0, tim1_store}, 32'hA5);

        // constrained random mix in the extended variant
        m_cmd = 0; m_stat = 8'h01; m_addr = 0; m_mode = 8'hC3; m_tim = 8'h77;
        for (int i = 0; i < 400; i++) begin
            logic wr, dw;
            logic [2:0] off;
            logic [31:0] d, exp;
            wr  = $urandom_range(0, 1) == 1;
            dw  = $urandom_range(0, 3) == 0;
            off = 3'($urandom_range(0, 7));
            d   = $urandom;
            exp = 32'hFFFF_FFFF;
            if (!dw) begin
                case (off)
                    3'd0: exp = {24'h0, m_cmd};
                    3'd1: exp = {24'h0, m_mode};
                    3'd2: exp = {24'h0, m_stat};
                    3'd3: exp = {24'h0, m_tim};
                    default: exp = {24'h0, m_addr[8*(off-4) +: 8]};
                endcase
            end else if (off == 3'd4) exp = m_addr;
            access(wr, dw, off, d, 0, "R2 random");
            if (!wr) check("R6 R8 R9 random read", rdv, exp);
            else if (dw) begin
                if (off == 3'd4) m_addr = d;
            end else begin
                case (off)
                    3'd0: m_cmd = d[7:0];
                    3'd1: m_mode = f_mode(m_mode, d[7:0]);
                    3'd2: m_stat = f_stat(m_stat, d[7:0], 1'b1);
                    3'd3: m_tim = d[7:0];
                    default: ;
                endcase
            end
            check("R3 random start", {31'h0, cmd_start}, {31'h0, m_cmd[0]});
            check("R5 random irq", {31'h0, irq_pending}, {31'h0, m_stat[2]});
        end
        check("R9 no foreign enable", stray, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule